// File: doc/BRIEF.md
# Non-Maskable Interrupt Entry Sequencer

This block performs interrupt entry on behalf of an 8-bit processor core. A single-cycle non-maskable request pulse is caught in a pending flag. The sequencer waits until the core reports an instruction boundary. It then takes over a byte-wide memory bus for five consecutive cycles. In those cycles it saves the return state on a stack in page 0x01, adjusts the status flags, and loads a new program counter from a two-byte vector.

The core hands over its program counter, stack pointer and status byte on input ports. The sequencer captures them when entry begins, and `busy` stays high while it owns the bus. The working copies appear on the output ports. A one-cycle `done` pulse tells the core to take the new PC, SP and status values. Instruction decode and maskable interrupt priority belong to the core.

Top module: `nmiEntrySeq`

## Requirements
- R1: A one-cycle `nmiReq` pulse sets a pending flag. Entry starts only on a clock edge where the block is idle, the flag is pending and `instBoundary` is high. While idle, `busy`, `memWe` and `memRe` stay low.
- R2: The first bus cycle after the start writes PC bits 15:8 to address 0x0100 + SP.
- R3: The second bus cycle writes PC bits 7:0 to address 0x0100 + ((SP − 1) mod 256).
- R4: The third bus cycle writes the status byte to address 0x0100 + ((SP − 2) mod 256). In that byte bit 4 (break) is cleared, bit 2 (interrupt disable) and bit 5 (unused) are set, and the other bits are unchanged.
- R5: The fourth bus cycle reads VEC_BASE, which gives PC bits 7:0. The fifth reads VEC_BASE + 1, which gives PC bits 15:8.
- R6: `done` is high for exactly one cycle, the cycle after the fifth access. In that cycle `pcOut` holds the vector, `spOut` is (SP − 3) mod 256 and `srOut` is the adjusted status. `busy` is high from the first access through the `done` cycle and low after it.
- R7: The stack pointer wraps within 8 bits. With SP = 0x01 the pushes go to 0x0101, 0x0100 and 0x01FF, and `spOut` ends at 0xFE.
- R8: A request that arrives while a sequence is running stays pending. It starts a new entry at the first instruction boundary after `done`.
- R9: In each cycle at most one of `memWe` and `memRe` is high.
- R10: The pending flag is cleared when servicing begins. After an entry with no further request, `instBoundary` does not start another sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiReq | input | 1 | One-cycle non-maskable request pulse |
| instBoundary | input | 1 | High when the core is between instructions |
| pcIn | input | 16 | Program counter from the core |
| spIn | input | 8 | Stack pointer from the core |
| srIn | input | 8 | Status byte from the core |
| pcOut | output | 16 | Working program counter (new PC at done) |
| spOut | output | 8 | Working stack pointer |
| srOut | output | 8 | Working status byte |
| busy | output | 1 | Sequencer owns the bus |
| done | output | 1 | One-cycle pulse when entry completes |
| memAddr | output | 16 | Bus address |
| memWe | output | 1 | Bus write strobe |
| memRe | output | 1 | Bus read strobe |
| memWdata | output | 8 | Bus write data |
| memRdata | input | 8 | Bus read data, valid in the same cycle as memRe |

## Verification
The bench sets VEC_BASE to 0xFFFE, so the high vector byte comes from 0xFFFF at the top of the address space. This checks that the vector address is taken from the parameter and is not fixed. Each case in the table uses its own SP value, and the cases include SP = 0x01 and SP = 0x00. Both therefore wrap across the bottom of the stack page.

// File: rtl/nmiSeqPkg.sv
package nmiSeqPkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int BRK_BIT = 4;
  localparam int IDIS_BIT = 2;
  localparam int SPARE_BIT = 5;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_PUSH_HI = 3'd1,
    S_PUSH_LO = 3'd2,
    S_PUSH_SR = 3'd3,
    S_VEC_LO  = 3'd4,
    S_VEC_HI  = 3'd5,
    S_DONE    = 3'd6
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic pushHi;
    logic pushLo;
    logic pushSr;
    logic fetchLo;
    logic fetchHi;
  } seqStrobes_t;
endpackage

// File: rtl/nmiSeqCtrl.sv
module nmiSeqCtrl
  import nmiSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        nmiReq,
  input  logic        instBoundary,
  output seqStrobes_t strb,
  output logic        busy,
  output logic        done
);
  seqState_t state, stateNext;
  logic pending;
  logic startNow;

  assign startNow = (state == S_IDLE) && pending && instBoundary;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:    if (startNow) stateNext = S_PUSH_HI;
      S_PUSH_HI: stateNext = S_PUSH_LO;
      S_PUSH_LO: stateNext = S_PUSH_SR;
      S_PUSH_SR: stateNext = S_VEC_LO;
      S_VEC_LO:  stateNext = S_VEC_HI;
      S_VEC_HI:  stateNext = S_DONE;
      S_DONE:    stateNext = S_IDLE;
      default:   stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      // a request in the start cycle survives the clear
      pending <= nmiReq | (pending & ~startNow);
    end
  end

  always_comb begin
    strb         = '0;
    strb.capture = startNow;
    strb.pushHi  = (state == S_PUSH_HI);
    strb.pushLo  = (state == S_PUSH_LO);
    strb.pushSr  = (state == S_PUSH_SR);
    strb.fetchLo = (state == S_VEC_LO);
    strb.fetchHi = (state == S_VEC_HI);
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  a_r1_start_gate: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !(pending && instBoundary)) |=> (state == S_IDLE));
  a_r2_push_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PUSH_HI) |=> (state == S_PUSH_LO));
  a_r4_status_after_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PUSH_LO) |=> (state == S_PUSH_SR));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_pending_clear: assert property (@(posedge clk) disable iff (!rstN)
    (startNow && !nmiReq) |=> !pending);
  a_r8_keep_pending: assert property (@(posedge clk) disable iff (!rstN)
    (busy && nmiReq) |=> pending);
endmodule

// File: rtl/nmiSeqPath.sv
module nmiSeqPath
  import nmiSeqPkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_BASE   = 16'hFFFA,
  parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] srIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] srOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWdata
);
  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_BASE + 16'd1;

  logic [ADDR_W-1:0] pcWork;
  logic [DATA_W-1:0] spWork;
  logic [DATA_W-1:0] srWork;
  logic              anyPush;
  logic [ADDR_W-1:0] stackAddr;
  logic [DATA_W-1:0] srAdjusted;

  assign anyPush   = strb.pushHi | strb.pushLo | strb.pushSr;
  assign stackAddr = STACK_BASE | {{(ADDR_W-DATA_W){1'b0}}, spWork};

  always_comb begin
    srAdjusted            = srWork;
    srAdjusted[BRK_BIT]   = 1'b0;
    srAdjusted[IDIS_BIT]  = 1'b1;
    srAdjusted[SPARE_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcWork <= '0;
      spWork <= '0;
      srWork <= '0;
    end else begin
      if (strb.capture) begin
        pcWork <= pcIn;
        spWork <= spIn;
        srWork <= srIn;
      end
      if (anyPush) spWork <= spWork - 8'd1;
      if (strb.pushLo) srWork <= srAdjusted;
      if (strb.fetchLo) pcWork[DATA_W-1:0] <= memRdata;
      if (strb.fetchHi) pcWork[ADDR_W-1:DATA_W] <= memRdata;
    end
  end

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    memWe    = anyPush;
    memRe    = strb.fetchLo | strb.fetchHi;
    if (strb.pushHi) begin
      memAddr  = stackAddr;
      memWdata = pcWork[ADDR_W-1:DATA_W];
    end else if (strb.pushLo) begin
      memAddr  = stackAddr;
      memWdata = pcWork[DATA_W-1:0];
    end else if (strb.pushSr) begin
      memAddr  = stackAddr;
      memWdata = srWork;
    end else if (strb.fetchLo) begin
      memAddr = VEC_BASE;
    end else if (strb.fetchHi) begin
      memAddr = VEC_HI_ADDR;
    end
  end

  assign pcOut = pcWork;
  assign spOut = spWork;
  assign srOut = srWork;

  a_r9_one_access: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));
  a_r7_sp_step: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (spWork == $past(spWork) - 8'd1));
  a_r4_flags_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushSr |-> (memWdata[IDIS_BIT] && memWdata[SPARE_BIT] && !memWdata[BRK_BIT]));
  a_r5_vec_stable_sp: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> $stable(spWork));
endmodule

// File: rtl/nmiEntrySeq.sv
module nmiEntrySeq
  import nmiSeqPkg::*;
#(
  parameter logic [15:0] VEC_BASE   = 16'hFFFA,
  parameter logic [15:0] STACK_BASE = 16'h0100
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        nmiReq,
  input  logic        instBoundary,
  input  logic [15:0] pcIn,
  input  logic [7:0]  spIn,
  input  logic [7:0]  srIn,
  output logic [15:0] pcOut,
  output logic [7:0]  spOut,
  output logic [7:0]  srOut,
  output logic        busy,
  output logic        done,
  output logic [15:0] memAddr,
  output logic        memWe,
  output logic        memRe,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata
);
  seqStrobes_t strb;

  nmiSeqCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .nmiReq       (nmiReq),
    .instBoundary (instBoundary),
    .strb         (strb),
    .busy         (busy),
    .done         (done)
  );

  nmiSeqPath #(
    .VEC_BASE   (VEC_BASE),
    .STACK_BASE (STACK_BASE)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pcIn     (pcIn),
    .spIn     (spIn),
    .srIn     (srIn),
    .memRdata (memRdata),
    .pcOut    (pcOut),
    .spOut    (spOut),
    .srOut    (srOut),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memRe    (memRe),
    .memWdata (memWdata)
  );

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWe && !memRe));
endmodule

// File: tb/tb_nmiEntrySeq.sv
module tb_nmiEntrySeq;
  localparam logic [15:0] VEC = 16'hFFFE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiReq = 1'b0, instBoundary = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0] spIn = '0, srIn = '0;
  logic [15:0] pcOut, memAddr;
  logic [7:0] spOut, srOut, memWdata, memRdata;
  logic busy, done, memWe, memRe;
  logic [7:0] vecLo = 8'h00, vecHi = 8'h00;
  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  assign memRdata = (memAddr == VEC) ? vecLo :
                    (memAddr == VEC + 16'd1) ? vecHi : 8'hEE;

  nmiEntrySeq #(.VEC_BASE(VEC)) dut (.*);

  typedef struct packed {
    logic [15:0] pc;
    logic [7:0]  sp;
    logic [7:0]  sr;
    logic [7:0]  vl;
    logic [7:0]  vh;
  } vec_t;

  localparam vec_t TABLE [5] = '{
    '{16'hC123, 8'hFD, 8'h00, 8'h34, 8'h12},
    '{16'h80FF, 8'h01, 8'hFF, 8'hCD, 8'hAB},
    '{16'h0000, 8'h00, 8'h10, 8'h00, 8'h80},
    '{16'hFFFF, 8'h80, 8'hC3, 8'hFF, 8'hFF},
    '{16'h5A5A, 8'h02, 8'h24, 8'h01, 8'hE0}
  };

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startEntry(input vec_t v);
    @(negedge clk);
    pcIn = v.pc; spIn = v.sp; srIn = v.sr; vecLo = v.vl; vecHi = v.vh;
    nmiReq = 1'b1;
    @(negedge clk);
    nmiReq = 1'b0;
    chk(busy == 1'b0, "R1 pending without boundary", busy, 0);
    instBoundary = 1'b1;
    @(negedge clk);
    instBoundary = 1'b0;
  endtask

  // observes the five bus cycles and the done cycle; first one already current
  task automatic checkEntry(input vec_t v, input bit injectMid);
    logic [7:0] srExp;
    srExp = (v.sr & 8'hEF) | 8'h24;
    chk(memWe && !memRe && memAddr == {8'h01, v.sp} && memWdata == v.pc[15:8],
        "R2 push pc high", {memAddr, memWdata}, {8'h01, v.sp, v.pc[15:8]});
    chk(busy == 1'b1, "R6 busy in sequence", busy, 1);
    @(negedge clk);
    chk(memWe && !memRe && memAddr == {8'h01, v.sp - 8'd1} && memWdata == v.pc[7:0],
        "R3 R7 push pc low", {memAddr, memWdata}, {8'h01, v.sp - 8'd1, v.pc[7:0]});
    if (injectMid) nmiReq = 1'b1;
    @(negedge clk);
    nmiReq = 1'b0;
    chk(memWe && !memRe && memAddr == {8'h01, v.sp - 8'd2} && memWdata == srExp,
        "R4 push status", {memAddr, memWdata}, {8'h01, v.sp - 8'd2, srExp});
    @(negedge clk);
    chk(memRe && !memWe && memAddr == VEC, "R5 R9 vector low read", memAddr, VEC);
    chk(done == 1'b0, "R6 no early done", done, 0);
    @(negedge clk);
    chk(memRe && !memWe && memAddr == VEC + 16'd1, "R5 vector high read", memAddr, VEC + 16'd1);
    @(negedge clk);
    chk(done && busy && !memWe && !memRe, "R6 done pulse", {done, busy}, 2'b11);
    chk(pcOut == {v.vh, v.vl}, "R5 new pc", pcOut, {v.vh, v.vl});
    chk(spOut == v.sp - 8'd3, "R6 R7 final sp", spOut, v.sp - 8'd3);
    chk(srOut == srExp, "R4 final status", srOut, srExp);
    @(negedge clk);
    chk(!done && !busy, "R6 done one cycle", {done, busy}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memWe && !memRe, "R1 reset state", {busy, done, memWe, memRe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    instBoundary = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !memWe && !memRe, "R1 boundary without request", busy, 0);
    instBoundary = 1'b0;

    foreach (TABLE[i]) begin
      startEntry(TABLE[i]);
      checkEntry(TABLE[i], 1'b0);
    end

    // R10: no new request, boundary must not restart
    instBoundary = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !memWe, "R10 pending cleared", busy, 0);
    instBoundary = 1'b0;

    // R8: request arriving mid-sequence is served at next boundary
    startEntry(TABLE[0]);
    checkEntry(TABLE[0], 1'b1);
    repeat (2) @(negedge clk);
    chk(!busy, "R8 waits for boundary", busy, 0);
    spIn = 8'h40;
    instBoundary = 1'b1;
    @(negedge clk);
    instBoundary = 1'b0;
    chk(busy && memWe && memAddr == 16'h0140, "R8 second entry starts", memAddr, 16'h0140);
    repeat (6) @(negedge clk);
    chk(!busy, "R8 second entry ends", busy, 0);
    instBoundary = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy, "R10 no third entry", busy, 0);
    instBoundary = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule